// File: doc/BRIEF.md
# Privileged control register unit

This unit keeps the five control registers of a 32-bit processor core: the status word, its saved copy, the saved program counter, a general base address and the exception vector base. The execution stage writes them through a single write port addressed by a 3-bit register select and reads them through a combinational read port. The status word is split into decoded outputs: privilege mode, register bank, block flag, cache lock, the divide-step flags, the interrupt mask, the saturation flag and the condition flag.

When the exception strobe is high, the unit saves the status word and the current program counter in one edge. In the same edge it forces privileged mode, the alternate register bank and the block flag. The interrupt mask is left as it was. A return strobe reloads the status word from its saved copy and presents the saved program counter as the next fetch address in the same cycle. The write port applies a mask that depends on privilege. User-mode code may change only the four arithmetic flags and the general base register. A user-mode attempt on a privileged-only register is dropped and reported with a one-cycle flag. The exception strobe is assumed already qualified upstream. The accept qualifier output exists for that upstream logic.

Top module: `priv_ctrl_regs`

## Requirements
- R1: Status word layout: mode at bit 30, bank at bit 29, block at bit 28, cache lock at bit 15, M at bit 9, Q at bit 8, interrupt mask at bits 7:4, S at bit 1, T at bit 0. Each decoded output equals its bit of `sr_o`.
- R2: All other status bits read 0 and ignore writes. The implemented-bit mask is 32'h700083F3.
- R3: After reset the status word is 32'h700000F0. The saved status word, saved PC, base registers and `illegal_o` are all 0.
- R4: In the cycle after `exc_i`, the saved status word holds the previous status word and the saved PC holds `pc_i`. Mode, bank and block are 1. `exc_i` overrides a return or a write in the same cycle.
- R5: An exception leaves the interrupt mask and every other status bit unchanged.
- R6: `accept_en_o` is the inverse of the block bit.
- R7: A status write in user mode (mode bit 0) changes only bits 9, 8, 1 and 0. A status write in privileged mode changes every implemented bit.
- R8: A user-mode write to the saved status word, saved PC or vector base is dropped. `illegal_o` is 1 during exactly the following cycle.
- R9: The general base register accepts writes in both modes.
- R10: With `rte_i` high and `exc_i` low, `next_pc_vld_o` is 1 and `next_pc_o` equals the saved PC in that same cycle. On the next cycle the status word equals the saved status word ANDed with the implemented-bit mask. A return overrides a write in the same cycle.
- R11: Select encoding, shared by read and write: 0 status, 1 saved status, 2 saved PC, 3 general base, 4 vector base. Selects 5 to 7 read 0, and a write to them changes nothing and raises no flag. `rd_data_o` follows `rd_sel_i` with no clock delay.
- R12: `vec_base_o` equals the vector base register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_i | input | XW | Program counter of the instruction taking the exception |
| exc_i | input | 1 | Exception or interrupt entry strobe |
| rte_i | input | 1 | Return-from-exception strobe |
| wr_en_i | input | 1 | Register write enable |
| wr_sel_i | input | 3 | Register select for writes |
| wr_data_i | input | XW | Write data |
| rd_sel_i | input | 3 | Register select for reads |
| rd_data_o | output | XW | Read data |
| sr_o | output | 32 | Status word |
| ssr_o | output | 32 | Saved status word |
| spc_o | output | XW | Saved program counter |
| gbr_o | output | XW | General base register |
| vbr_o | output | XW | Vector base register |
| vec_base_o | output | XW | Exception vector base |
| priv_o | output | 1 | Privileged mode |
| bank_o | output | 1 | Register bank select |
| block_o | output | 1 | Block flag |
| cache_lock_o | output | 1 | Cache lock enable |
| m_o | output | 1 | Divide-step M flag |
| q_o | output | 1 | Divide-step Q flag |
| imask_o | output | 4 | Interrupt mask level |
| s_o | output | 1 | Saturation flag |
| t_o | output | 1 | Condition flag |
| accept_en_o | output | 1 | Exceptions and interrupts may be accepted |
| next_pc_o | output | XW | Return address |
| next_pc_vld_o | output | 1 | Return address valid |
| illegal_o | output | 1 | Privileged-only write attempted in user mode |

## Verification
Register effects from a write, an exception or a return show up on the outputs one clock after the edge that captures the strobe. The return address, its valid flag and the read port are combinational and belong to the cycle in which the strobe is applied. The denied-write flag rises one cycle after the attempt and lasts one cycle. The bench drives every stimulus at a falling edge. It samples the combinational results 1 ns later, before the rising edge, and samples the registered results 1 ns after that edge. A reference model kept in the bench is advanced once per edge. Each step is therefore compared with the model state of exactly one edge.

// File: rtl/privreg_pkg.sv
package privreg_pkg;

  localparam int SRW      = 32;
  localparam int B_MODE   = 30;
  localparam int B_BANK   = 29;
  localparam int B_BLOCK  = 28;
  localparam int B_CLOCK  = 15;
  localparam int B_M      = 9;
  localparam int B_Q      = 8;
  localparam int B_IM_LO  = 4;
  localparam int IM_W     = 4;
  localparam int B_S      = 1;
  localparam int B_T      = 0;

  typedef enum logic [2:0] {
    SEL_SR  = 3'd0,
    SEL_SSR = 3'd1,
    SEL_SPC = 3'd2,
    SEL_GBR = 3'd3,
    SEL_VBR = 3'd4
  } creg_sel_e;

  localparam logic [SRW-1:0] ENTRY_BITS =
    (SRW'(1) << B_MODE) | (SRW'(1) << B_BANK) | (SRW'(1) << B_BLOCK);
  localparam logic [SRW-1:0] USER_BITS =
    (SRW'(1) << B_M) | (SRW'(1) << B_Q) | (SRW'(1) << B_S) | (SRW'(1) << B_T);
  localparam logic [SRW-1:0] IMASK_BITS = SRW'((1 << IM_W) - 1) << B_IM_LO;
  localparam logic [SRW-1:0] IMPL_BITS  =
    ENTRY_BITS | USER_BITS | IMASK_BITS | (SRW'(1) << B_CLOCK);
  localparam logic [SRW-1:0] SR_RESET   = ENTRY_BITS | IMASK_BITS;

  // Drop every reserved bit of a status value.
  function automatic logic [SRW-1:0] sr_clean(input logic [SRW-1:0] v);
    return v & IMPL_BITS;
  endfunction

  // Merge write data into the status word under the privilege mask.
  function automatic logic [SRW-1:0] sr_merge(input logic [SRW-1:0] old_v,
                                              input logic [SRW-1:0] data,
                                              input logic       priv);
    logic [SRW-1:0] m;
    m = priv ? IMPL_BITS : USER_BITS;
    return (old_v & ~m) | (data & m);
  endfunction

  // Status value after exception entry: mode, bank and block forced high.
  function automatic logic [SRW-1:0] sr_on_entry(input logic [SRW-1:0] v);
    return v | ENTRY_BITS;
  endfunction

endpackage

// File: rtl/privreg_status.sv
module privreg_status
  import privreg_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ev_exc,
  input  logic           ev_rte,
  input  logic           ev_wr_sr,
  input  logic [SRW-1:0] wr_data,
  input  logic [SRW-1:0] ssr_i,
  output logic [SRW-1:0] sr_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)        sr_q <= SR_RESET;
    else if (ev_exc)   sr_q <= sr_on_entry(sr_q);
    else if (ev_rte)   sr_q <= sr_clean(ssr_i);
    else if (ev_wr_sr) sr_q <= sr_merge(sr_q, wr_data, sr_q[B_MODE]);
  end

endmodule

// File: rtl/privreg_save.sv
module privreg_save
  import privreg_pkg::*;
#(
  parameter int XW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ev_exc,
  input  logic [SRW-1:0] sr_i,
  input  logic [XW-1:0]  pc_i,
  input  logic           ev_wr_ssr,
  input  logic           ev_wr_spc,
  input  logic [XW-1:0]  wr_data,
  output logic [SRW-1:0] ssr_q,
  output logic [XW-1:0]  spc_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ssr_q <= '0;
      spc_q <= '0;
    end else if (ev_exc) begin
      ssr_q <= sr_i;
      spc_q <= pc_i;
    end else begin
      if (ev_wr_ssr) ssr_q <= wr_data[SRW-1:0];
      if (ev_wr_spc) spc_q <= wr_data;
    end
  end

endmodule

// File: rtl/privreg_base.sv
module privreg_base #(
  parameter int XW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_wr_gbr,
  input  logic          ev_wr_vbr,
  input  logic [XW-1:0] wr_data,
  output logic [XW-1:0] gbr_q,
  output logic [XW-1:0] vbr_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gbr_q <= '0;
      vbr_q <= '0;
    end else begin
      if (ev_wr_gbr) gbr_q <= wr_data;
      if (ev_wr_vbr) vbr_q <= wr_data;
    end
  end

endmodule

// File: rtl/priv_ctrl_regs.sv
module priv_ctrl_regs
  import privreg_pkg::*;
#(
  parameter int XW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [XW-1:0] pc_i,
  input  logic          exc_i,
  input  logic          rte_i,
  input  logic          wr_en_i,
  input  logic [2:0]    wr_sel_i,
  input  logic [XW-1:0] wr_data_i,
  input  logic [2:0]    rd_sel_i,
  output logic [XW-1:0] rd_data_o,
  output logic [31:0]   sr_o,
  output logic [31:0]   ssr_o,
  output logic [XW-1:0] spc_o,
  output logic [XW-1:0] gbr_o,
  output logic [XW-1:0] vbr_o,
  output logic [XW-1:0] vec_base_o,
  output logic          priv_o,
  output logic          bank_o,
  output logic          block_o,
  output logic          cache_lock_o,
  output logic          m_o,
  output logic          q_o,
  output logic [3:0]    imask_o,
  output logic          s_o,
  output logic          t_o,
  output logic          accept_en_o,
  output logic [XW-1:0] next_pc_o,
  output logic          next_pc_vld_o,
  output logic          illegal_o
);

  logic [SRW-1:0] sr_q, ssr_q;
  logic [XW-1:0]  spc_q, gbr_q, vbr_q;

  // Named internal events, exported to the bound checker.
  logic ev_exc, ev_rte, ev_wr, in_priv, sel_priv_only;
  logic ev_wr_sr, ev_wr_ssr, ev_wr_spc, ev_wr_gbr, ev_wr_vbr, ev_deny;
  logic illegal_q;

  assign in_priv       = sr_q[B_MODE];
  assign ev_exc        = exc_i;
  assign ev_rte        = rte_i & ~exc_i;
  assign ev_wr         = wr_en_i & ~exc_i & ~rte_i;
  assign sel_priv_only = (wr_sel_i == SEL_SSR) | (wr_sel_i == SEL_SPC) |
                         (wr_sel_i == SEL_VBR);
  assign ev_wr_sr      = ev_wr & (wr_sel_i == SEL_SR);
  assign ev_wr_gbr     = ev_wr & (wr_sel_i == SEL_GBR);
  assign ev_wr_ssr     = ev_wr & in_priv & (wr_sel_i == SEL_SSR);
  assign ev_wr_spc     = ev_wr & in_priv & (wr_sel_i == SEL_SPC);
  assign ev_wr_vbr     = ev_wr & in_priv & (wr_sel_i == SEL_VBR);
  assign ev_deny       = ev_wr & ~in_priv & sel_priv_only;

  privreg_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_exc   (ev_exc),
    .ev_rte   (ev_rte),
    .ev_wr_sr (ev_wr_sr),
    .wr_data  (wr_data_i[SRW-1:0]),
    .ssr_i    (ssr_q),
    .sr_q     (sr_q)
  );

  privreg_save #(.XW(XW)) u_save (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_exc    (ev_exc),
    .sr_i      (sr_q),
    .pc_i      (pc_i),
    .ev_wr_ssr (ev_wr_ssr),
    .ev_wr_spc (ev_wr_spc),
    .wr_data   (wr_data_i),
    .ssr_q     (ssr_q),
    .spc_q     (spc_q)
  );

  privreg_base #(.XW(XW)) u_base (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_wr_gbr (ev_wr_gbr),
    .ev_wr_vbr (ev_wr_vbr),
    .wr_data   (wr_data_i),
    .gbr_q     (gbr_q),
    .vbr_q     (vbr_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) illegal_q <= 1'b0;
    else        illegal_q <= ev_deny;
  end

  always_comb begin
    case (rd_sel_i)
      SEL_SR:  rd_data_o = XW'(sr_q);
      SEL_SSR: rd_data_o = XW'(ssr_q);
      SEL_SPC: rd_data_o = spc_q;
      SEL_GBR: rd_data_o = gbr_q;
      SEL_VBR: rd_data_o = vbr_q;
      default: rd_data_o = '0;
    endcase
  end

  assign sr_o          = sr_q;
  assign ssr_o         = ssr_q;
  assign spc_o         = spc_q;
  assign gbr_o         = gbr_q;
  assign vbr_o         = vbr_q;
  assign vec_base_o    = vbr_q;
  assign priv_o        = sr_q[B_MODE];
  assign bank_o        = sr_q[B_BANK];
  assign block_o       = sr_q[B_BLOCK];
  assign cache_lock_o  = sr_q[B_CLOCK];
  assign m_o           = sr_q[B_M];
  assign q_o           = sr_q[B_Q];
  assign imask_o       = sr_q[B_IM_LO +: IM_W];
  assign s_o           = sr_q[B_S];
  assign t_o           = sr_q[B_T];
  assign accept_en_o   = ~sr_q[B_BLOCK];
  assign next_pc_o     = spc_q;
  assign next_pc_vld_o = ev_rte;
  assign illegal_o     = illegal_q;

endmodule

// File: rtl/priv_ctrl_regs_chk.sv
module priv_ctrl_regs_chk
  import privreg_pkg::*;
#(
  parameter int XW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          exc_i,
  input logic [XW-1:0] pc_i,
  input logic [XW-1:0] wr_data_i,
  input logic [31:0]   sr_o,
  input logic [31:0]   ssr_o,
  input logic [XW-1:0] spc_o,
  input logic [XW-1:0] gbr_o,
  input logic          accept_en_o,
  input logic          illegal_o,
  input logic          ev_rte,
  input logic          ev_wr_sr,
  input logic          ev_wr_gbr,
  input logic          ev_deny
);

  // R4: saves happen on the edge after the strobe
  a_r4_saves: assert property (@(posedge clk) disable iff (!rst_n)
    exc_i |=> (ssr_o == $past(sr_o)) && (spc_o == $past(pc_i)));

  a_r4_entry_bits: assert property (@(posedge clk) disable iff (!rst_n)
    exc_i |=> sr_o[B_MODE] && sr_o[B_BANK] && sr_o[B_BLOCK]);

  // R5
  a_r5_mask_kept: assert property (@(posedge clk) disable iff (!rst_n)
    exc_i |=> sr_o[B_IM_LO +: IM_W] == $past(sr_o[B_IM_LO +: IM_W]));

  // R6
  a_r6_block_after_entry: assert property (@(posedge clk) disable iff (!rst_n)
    exc_i |=> !accept_en_o);

  // R7: user-mode status write keeps everything but the four flags
  a_r7_user_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wr_sr && !sr_o[B_MODE]) |=> ((sr_o & ~USER_BITS) == $past(sr_o & ~USER_BITS)));

  // R8
  a_r8_flag_raise: assert property (@(posedge clk) disable iff (!rst_n)
    ev_deny |=> illegal_o);

  a_r8_flag_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_deny |=> !illegal_o);

  // R9
  a_r9_gbr_write: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_gbr |=> gbr_o == $past(wr_data_i));

  // R10
  a_r10_restore: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rte |=> sr_o == ($past(ssr_o) & IMPL_BITS));

  // R2
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_o & ~IMPL_BITS) == '0);

endmodule

bind priv_ctrl_regs priv_ctrl_regs_chk #(.XW(XW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .exc_i       (exc_i),
  .pc_i        (pc_i),
  .wr_data_i   (wr_data_i),
  .sr_o        (sr_o),
  .ssr_o       (ssr_o),
  .spc_o       (spc_o),
  .gbr_o       (gbr_o),
  .accept_en_o (accept_en_o),
  .illegal_o   (illegal_o),
  .ev_rte      (ev_rte),
  .ev_wr_sr    (ev_wr_sr),
  .ev_wr_gbr   (ev_wr_gbr),
  .ev_deny     (ev_deny)
);

// File: tb/test_priv_ctrl_regs.sv
module test_priv_ctrl_regs;

  localparam int XW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [XW-1:0] pc_i = '0;
  logic          exc_i = 1'b0, rte_i = 1'b0, wr_en_i = 1'b0;
  logic [2:0]    wr_sel_i = '0, rd_sel_i = '0;
  logic [XW-1:0] wr_data_i = '0;
  logic [XW-1:0] rd_data_o, spc_o, gbr_o, vbr_o, vec_base_o, next_pc_o;
  logic [31:0]   sr_o, ssr_o;
  logic          priv_o, bank_o, block_o, cache_lock_o, m_o, q_o, s_o, t_o;
  logic [3:0]    imask_o;
  logic          accept_en_o, next_pc_vld_o, illegal_o;

  always #2 clk = ~clk;

  priv_ctrl_regs #(.XW(XW)) i_priv_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .exc_i(exc_i), .rte_i(rte_i),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o), .sr_o(sr_o), .ssr_o(ssr_o),
    .spc_o(spc_o), .gbr_o(gbr_o), .vbr_o(vbr_o), .vec_base_o(vec_base_o),
    .priv_o(priv_o), .bank_o(bank_o), .block_o(block_o),
    .cache_lock_o(cache_lock_o), .m_o(m_o), .q_o(q_o), .imask_o(imask_o),
    .s_o(s_o), .t_o(t_o), .accept_en_o(accept_en_o), .next_pc_o(next_pc_o),
    .next_pc_vld_o(next_pc_vld_o), .illegal_o(illegal_o)
  );

  int n_chk = 0, n_bad = 0;
  logic [31:0] m_sr, m_ssr, m_spc, m_gbr, m_vbr;
  logic        m_ill;

  function automatic logic [31:0] bit_at(input int b);
    return 32'd1 << b;
  endfunction

  function automatic logic [31:0] flag_set();
    return bit_at(0) | bit_at(1) | bit_at(8) | bit_at(9);
  endfunction

  function automatic logic [31:0] live_set();
    return flag_set() | bit_at(15) | bit_at(28) | bit_at(29) | bit_at(30) |
           (32'd15 * bit_at(4));
  endfunction

  function automatic logic [31:0] model_read(input logic [2:0] sel);
    case (sel)
      3'd0: return m_sr;
      3'd1: return m_ssr;
      3'd2: return m_spc;
      3'd3: return m_gbr;
      3'd4: return m_vbr;
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    logic [12:0] dec_exp;
    check({tag, " sr"}, sr_o, m_sr);
    check({tag, " ssr"}, ssr_o, m_ssr);
    check({tag, " spc"}, spc_o, m_spc);
    check({tag, " R9 gbr"}, gbr_o, m_gbr);
    check({tag, " vbr"}, vbr_o, m_vbr);
    check("R12 vector base", vec_base_o, m_vbr);
    check("R8 illegal flag", {31'd0, illegal_o}, {31'd0, m_ill});
    check("R6 accept enable", {31'd0, accept_en_o}, {31'd0, ~m_sr[28]});
    dec_exp = {m_sr[30], m_sr[29], m_sr[28], m_sr[15], m_sr[9], m_sr[8],
               m_sr[7:4], m_sr[1], m_sr[0], 1'b0};
    check("R1 decoded fields",
          {19'd0, priv_o, bank_o, block_o, cache_lock_o, m_o, q_o, imask_o, s_o, t_o, 1'b0},
          {19'd0, dec_exp});
  endtask

  task automatic step(input logic e, input logic r, input logic w,
                      input logic [2:0] sel, input logic [31:0] d,
                      input logic [31:0] pc, input string tag);
    logic [31:0] msk;
    @(negedge clk);
    exc_i = e; rte_i = r; wr_en_i = w; wr_sel_i = sel; rd_sel_i = sel;
    wr_data_i = d; pc_i = pc;
    #1;
    check("R10 return valid", {31'd0, next_pc_vld_o}, {31'd0, r & ~e});
    if (r && !e) check("R10 return address", next_pc_o, m_spc);
    check("R11 read port", rd_data_o, model_read(sel));
    m_ill = 1'b0;
    if (e) begin
      m_ssr = m_sr; m_spc = pc;
      m_sr  = m_sr | bit_at(28) | bit_at(29) | bit_at(30);
    end else if (r) begin
      m_sr = m_ssr & live_set();
    end else if (w) begin
      case (sel)
        3'd0: begin
          msk  = m_sr[30] ? live_set() : flag_set();
          m_sr = (m_sr & ~msk) | (d & msk);
        end
        3'd1: if (m_sr[30]) m_ssr = d; else m_ill = 1'b1;
        3'd2: if (m_sr[30]) m_spc = d; else m_ill = 1'b1;
        3'd3: m_gbr = d;
        3'd4: if (m_sr[30]) m_vbr = d; else m_ill = 1'b1;
        default: ;
      endcase
    end
    @(posedge clk); #1;
    compare_all(tag);
    exc_i = 1'b0; rte_i = 1'b0; wr_en_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [31:0] lf;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    m_sr = 32'h700000F0; m_ssr = 0; m_spc = 0; m_gbr = 0; m_vbr = 0; m_ill = 0;
    #1;
    compare_all("R3 reset");
    check("R3 reset sr value", sr_o, 32'h700000F0);

    // R7 R11 R2: sweep every select with several patterns in both modes
    for (int rep = 0; rep < 2; rep++) begin
      for (int p = 0; p < 4; p++) begin
        for (int s = 0; s < 8; s++) begin
          logic [31:0] d;
          d = (p == 0) ? 32'hFFFF_FFFF : (p == 1) ? 32'h0 :
              (p == 2) ? 32'hA5A5_5A5A : 32'h1234_5678 ^ (32'(s) << 20);
          step(1'b0, 1'b0, 1'b1, 3'(s), d, 32'h0, "R7 R2 R11 sweep");
        end
        step(1'b1, 1'b0, 1'b0, 3'd0, 32'h0, 32'h8000_0100 + 32'(p), "R4 entry");
      end
    end

    // R5: mask kept across entry from user mode
    step(1'b0, 1'b0, 1'b1, 3'd0, 32'h0000_03A3, 0, "R7 to user");
    step(1'b1, 1'b0, 1'b0, 3'd0, 32'h0, 32'h8000_1234, "R5 entry keeps mask");
    check("R5 mask value", {28'd0, imask_o}, 32'hA);
    step(1'b0, 1'b1, 1'b0, 3'd0, 32'h0, 0, "R10 return");
    check("R10 restored sr", sr_o, 32'h0000_03A3);

    // R8: denied writes, then an idle cycle clears the flag
    step(1'b0, 1'b0, 1'b1, 3'd4, 32'hDEAD_BEEF, 0, "R8 deny vbr");
    step(1'b0, 1'b0, 1'b0, 3'd0, 32'h0, 0, "R8 idle after deny");
    step(1'b0, 1'b0, 1'b1, 3'd3, 32'hCAFE_0001, 0, "R9 user gbr");
    step(1'b0, 1'b0, 1'b1, 3'd6, 32'hFFFF_FFFF, 0, "R11 unused select");

    // R4 priority: all three strobes together; R10 priority over write
    step(1'b1, 1'b1, 1'b1, 3'd0, 32'h0, 32'h0000_4444, "R4 priority");
    step(1'b0, 1'b0, 1'b1, 3'd1, 32'hFFFF_FFFF, 0, "R2 ssr all ones");
    step(1'b0, 1'b1, 1'b1, 3'd0, 32'h0, 0, "R10 priority");
    check("R2 restored mask", sr_o, 32'h7000_83F3);
    step(1'b0, 1'b0, 1'b1, 3'd0, 32'h6000_0000, 0, "R6 clear block");
    check("R6 accept high", {31'd0, accept_en_o}, 32'd1);

    // mixed traffic
    lf = 32'h1ACE_B00C;
    for (int i = 0; i < 600; i++) begin
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      case (lf[3:0])
        4'd0:    step(1'b1, lf[4], lf[5], lf[8:6], lf, lf ^ 32'h5555_0000, "R4 mixed");
        4'd1,
        4'd2:    step(1'b0, 1'b1, lf[5], lf[8:6], lf, 0, "R10 mixed");
        default: step(1'b0, 1'b0, 1'b1, lf[8:6], {lf[31:9], lf[8:0] ^ 9'h1F3}, 0, "R7 R8 mixed");
      endcase
    end
    finish_run();
  end

endmodule